// File: doc/BRIEF.md
# Processor Interrupt Request Arbiter

This block sits beside an instruction sequencer. At every instruction boundary it decides whether control should go to an interrupt handler, and which 8-bit vector that handler uses. It watches an asynchronous level-sensitive maskable request and an asynchronous non-maskable request. It also reads the core's trap and interrupt-enable flags and takes strobes for the instruction boundary and the interrupt return. A halt indication lets it tell a halted core when to resume.

The non-maskable line is synchronised and then qualified by pulse width before it counts as an event. A taken non-maskable request opens a protected window that lasts until the next interrupt return. Inside that window nothing else is serviced, and one extra non-maskable event is kept in a single pending slot. A maskable request is not vectored internally. The block asks the bus side for two acknowledge cycles and takes the vector from the data of the second one. The core is expected to clear its interrupt-enable flag, and the trap flag for a single-step entry, when it sees the take pulse.

Top module: `irq_arbiter`

## Requirements
- R1: Both request inputs pass through a two-flop synchroniser before any decision uses them. A maskable request that rises in the same cycle as a boundary strobe is therefore not serviced at that boundary.
- R2: A non-maskable event is recognised only when the synchronised line was low for at least 4 consecutive clocks before its rising edge and then stays high for 4 consecutive clocks. The event is registered in the 4th high clock. A shorter high pulse or a shorter low gap produces no event.
- R3: A pending non-maskable request is taken at a boundary strobe. `take_o` pulses in the next cycle with `vector_o` = 2. `ack_req_o` is not raised, and `int_en_i` has no influence.
- R4: At a boundary with the synchronised maskable request high and `int_en_i` = 1, `ack_req_o` rises in the next cycle. It stays high until the second `ack_done_i` pulse and falls in the cycle after that pulse. In that same cycle `take_o` pulses and `vector_o` carries the `ack_data_i` value presented with the second pulse.
- R5: With `int_en_i` = 0 a maskable request starts no acknowledge sequence and produces no take.
- R6: When several sources are ready at one boundary, the order is single-step (trap flag set, `vector_o` = 1), then non-maskable (2), then maskable.
- R7: From a non-maskable take until the next `iret_i` pulse, neither a maskable request nor a new non-maskable event is serviced at a boundary.
- R8: The first non-maskable event inside that window is held pending. It becomes a request when `iret_i` closes the window and is taken at the following boundary. Any further events in the same window are dropped.
- R9: `halt_exit_o` is high while `halted_i` is high and either a non-maskable request is waiting, or the synchronised maskable request is high with `int_en_i` = 1 outside a non-maskable window.
- R10: After a synchronous active-low reset, `take_o`, `vector_o`, `ack_req_o` and `halt_exit_o` are all zero, and no request is pending.
- R11: Boundary strobes that arrive while `ack_req_o` is high are ignored, including one with the trap flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mask_req_i | input | 1 | Asynchronous maskable level request |
| nmi_req_i | input | 1 | Asynchronous non-maskable request |
| trap_flag_i | input | 1 | Core trap (single-step) flag |
| int_en_i | input | 1 | Core interrupt-enable flag |
| boundary_i | input | 1 | One-cycle instruction-boundary strobe |
| iret_i | input | 1 | One-cycle interrupt-return strobe |
| halted_i | input | 1 | Core is halted |
| ack_done_i | input | 1 | One acknowledge cycle completed |
| ack_data_i | input | 8 | Data returned by the acknowledge cycle |
| take_o | output | 1 | One-cycle take-interrupt pulse |
| vector_o | output | 8 | Vector of the latest take, held |
| ack_req_o | output | 1 | Request for the external acknowledge sequence |
| halt_exit_o | output | 1 | Halted core should resume |

## Verification
The hardest state to reach is a non-maskable window that has a pending slot filled and a later event dropped. Reaching it takes a width-qualified pulse, a boundary, a second qualified pulse with a fresh low gap of at least four clocks, and a third one, all before the return strobe. The bench builds that chain from timed pulse tasks. It then shows at the ports that exactly one extra vector-2 take follows the return, and none follows a second return. Pulses that just miss the width limits, on either the low or the high side, are driven next to qualified ones, so that the synchroniser latency and the edge timing are observed cycle by cycle against the reference model.

// File: rtl/irq_arb_pkg.sv
// Package: shared constants and types for the interrupt request arbiter.
package irq_arb_pkg;
    localparam int VEC_W = 8;
    typedef logic [VEC_W-1:0] vec_t;
    localparam vec_t STEP_VEC = vec_t'(1);
    localparam vec_t NMI_VEC  = vec_t'(2);

    // Source chosen at a boundary, in descending priority
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_STEP = 2'd1,
        SRC_NMI  = 2'd2,
        SRC_MASK = 2'd3
    } irq_src_e;
endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// Multi-stage synchroniser for one asynchronous level.
// Assumes STAGES >= 1; reset clears every stage to low.
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stage_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop captures the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= 1'b0;
                else        stage_q[0] <= d_i;
            end
        end else begin : g_next
            // Later flops resolve metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= 1'b0;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/nmi_qualifier.sv
// Module: nmi_qualifier
// Turns a synchronised level into one event per qualified rising edge.
// The level must be low LOW_MIN clocks before the edge. The event fires
// in the HIGH_MIN-th high clock. Assumes HIGH_MIN >= 2.
module nmi_qualifier #(
    parameter int LOW_MIN  = 4,
    parameter int HIGH_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic fire_o
);
    localparam int LIM   = (LOW_MIN > HIGH_MIN) ? LOW_MIN : HIGH_MIN;
    localparam int CNT_W = $clog2(LIM + 1);
    localparam logic [CNT_W-1:0] LO_LIM  = CNT_W'(LOW_MIN);
    localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(HIGH_MIN - 1);

    logic             prev_q;
    logic             armed_q;
    logic [CNT_W-1:0] lo_cnt_q;
    logic [CNT_W-1:0] hi_cnt_q;

    assign fire_o = lvl_i & prev_q & armed_q & (hi_cnt_q == HI_LAST);

    // Track low-run and high-run lengths around each edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            armed_q  <= 1'b0;
            lo_cnt_q <= '0;
            hi_cnt_q <= '0;
        end else begin
            prev_q <= lvl_i;
            if (!lvl_i) begin
                lo_cnt_q <= (lo_cnt_q == LO_LIM) ? lo_cnt_q : lo_cnt_q + 1'b1;
                hi_cnt_q <= '0;
                armed_q  <= 1'b0;
            end else if (!prev_q) begin
                armed_q  <= (lo_cnt_q >= LO_LIM);
                hi_cnt_q <= CNT_W'(1);
                lo_cnt_q <= '0;
            end else begin
                lo_cnt_q <= '0;
                if (armed_q) hi_cnt_q <= hi_cnt_q + 1'b1;
                if (fire_o)  armed_q  <= 1'b0;
            end
        end
    end

    // R2
    single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
endmodule

// File: rtl/nmi_track.sv
// Module: nmi_track
// Holds the non-maskable request, the in-handler window and one pending slot.
// Assumes take_i is raised only while req_o is high and busy_o is low.
module nmi_track (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic take_i,
    input  logic iret_i,
    output logic req_o,
    output logic busy_o
);
    logic pend_q;

    // Route events into request or pending slot; open and close the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o  <= 1'b0;
            busy_o <= 1'b0;
            pend_q <= 1'b0;
        end else if (take_i) begin
            req_o  <= 1'b0;
            busy_o <= 1'b1;
            pend_q <= evt_i;
        end else if (iret_i && busy_o) begin
            busy_o <= 1'b0;
            req_o  <= pend_q | evt_i;
            pend_q <= 1'b0;
        end else if (evt_i) begin
            if (busy_o) pend_q <= 1'b1;
            else        req_o  <= 1'b1;
        end
    end

    // R8
    pend_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> busy_o);
endmodule

// File: rtl/irq_arbiter.sv
// Module: irq_arbiter (top)
// Chooses at each boundary between single-step, non-maskable and maskable
// entry. Runs the two-cycle acknowledge handshake for maskable requests.
// Assumes boundary_i, iret_i and ack_done_i are one-cycle strobes and the
// core clears its enable and trap flags on take_o.
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int NMI_LOW_MIN  = 4,
    parameter int NMI_HIGH_MIN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mask_req_i,
    input  logic       nmi_req_i,
    input  logic       trap_flag_i,
    input  logic       int_en_i,
    input  logic       boundary_i,
    input  logic       iret_i,
    input  logic       halted_i,
    input  logic       ack_done_i,
    input  logic [7:0] ack_data_i,
    output logic       take_o,
    output logic [7:0] vector_o,
    output logic       ack_req_o,
    output logic       halt_exit_o
);
    logic     mask_lvl, nmi_lvl, nmi_evt;
    logic     nmi_req, nmi_busy;
    logic     ack_first_q;
    irq_src_e src;

    irq_sync #(.STAGES(SYNC_STAGES)) u_mask_sync (
        .clk(clk), .rst_n(rst_n), .d_i(mask_req_i), .q_o(mask_lvl));
    irq_sync #(.STAGES(SYNC_STAGES)) u_nmi_sync (
        .clk(clk), .rst_n(rst_n), .d_i(nmi_req_i), .q_o(nmi_lvl));

    nmi_qualifier #(.LOW_MIN(NMI_LOW_MIN), .HIGH_MIN(NMI_HIGH_MIN)) u_qual (
        .clk(clk), .rst_n(rst_n), .lvl_i(nmi_lvl), .fire_o(nmi_evt));

    nmi_track u_track (
        .clk(clk), .rst_n(rst_n), .evt_i(nmi_evt), .take_i(src == SRC_NMI),
        .iret_i(iret_i), .req_o(nmi_req), .busy_o(nmi_busy));

    // Priority pick at an accepted boundary
    always_comb begin
        src = SRC_NONE;
        if (boundary_i && !ack_req_o) begin
            if (trap_flag_i)                              src = SRC_STEP;
            else if (nmi_req)                             src = SRC_NMI;
            else if (mask_lvl && int_en_i && !nmi_busy)   src = SRC_MASK;
        end
    end

    // Take pulse, held vector and acknowledge handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o      <= 1'b0;
            vector_o    <= '0;
            ack_req_o   <= 1'b0;
            ack_first_q <= 1'b0;
        end else begin
            take_o <= 1'b0;
            case (src)
                SRC_STEP: begin take_o <= 1'b1; vector_o <= STEP_VEC; end
                SRC_NMI:  begin take_o <= 1'b1; vector_o <= NMI_VEC;  end
                SRC_MASK: begin ack_req_o <= 1'b1; ack_first_q <= 1'b0; end
                default: begin
                    if (ack_req_o && ack_done_i) begin
                        if (!ack_first_q) begin
                            ack_first_q <= 1'b1;
                        end else begin
                            ack_first_q <= 1'b0;
                            ack_req_o   <= 1'b0;
                            take_o      <= 1'b1;
                            vector_o    <= ack_data_i;
                        end
                    end
                end
            endcase
        end
    end

    // Resume a halted core on a serviceable request
    assign halt_exit_o = halted_i & (nmi_req | (mask_lvl & int_en_i & ~nmi_busy));

    // R4
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req_o && !ack_done_i) |=> ack_req_o);
    // R3
    nmi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_NMI) |=> (take_o && vector_o == NMI_VEC && nmi_busy));
    // R6
    step_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_STEP) |=> (take_o && vector_o == STEP_VEC));
    // R7
    window_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_busy |=> !$rose(ack_req_o));
    // R11
    bnd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req_o && boundary_i && !ack_done_i) |=> !take_o);
endmodule

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mask_in = 0, nmi_in = 0, trap_f = 0, ie_f = 0, bnd = 0, iret_s = 0;
    logic halted = 0, ack_done = 0;
    logic [7:0] ack_data = 8'h00;
    logic take, ack_req, hexit;
    logic [7:0] vec;

    int n_chk = 0, n_fail = 0;
    string cur_req = "R10";
    logic [7:0] obs_q[$];
    bit ack_seen = 0;

    // reference model state
    bit m_s1, m_s2, m_ms1, m_ms2, m_qual, m_req, m_busy, m_pend, m_ack, m_first, m_take;
    int m_lr, m_hr;
    logic [7:0] m_vec;

    always #10 clk = ~clk;

    irq_arbiter u_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .mask_req_i(mask_in), .nmi_req_i(nmi_in),
        .trap_flag_i(trap_f), .int_en_i(ie_f), .boundary_i(bnd), .iret_i(iret_s),
        .halted_i(halted), .ack_done_i(ack_done), .ack_data_i(ack_data),
        .take_o(take), .vector_o(vec), .ack_req_o(ack_req), .halt_exit_o(hexit));

    // behavioural reference, advanced once per clock
    always @(posedge clk) begin
        bit ev, cd, ts, tn, sm, tk;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_ms1 = 0; m_ms2 = 0; m_qual = 0; m_req = 0;
            m_busy = 0; m_pend = 0; m_ack = 0; m_first = 0; m_take = 0;
            m_lr = 0; m_hr = 0; m_vec = 8'h00;
        end else begin
            ev = 0;
            if (m_s2) begin
                if (m_hr == 0) m_qual = (m_lr >= 4);
                m_hr++;
                ev = m_qual && (m_hr == 4);
                m_lr = 0;
            end else begin
                m_lr++;
                m_hr = 0;
            end
            cd = bnd && !m_ack;
            ts = cd && trap_f;
            tn = cd && !trap_f && m_req;
            sm = cd && !trap_f && !m_req && m_ms2 && ie_f && !m_busy;
            tk = 0;
            if (ts) begin tk = 1; m_vec = 8'd1; end
            if (tn) begin tk = 1; m_vec = 8'd2; end
            if (sm) begin m_ack = 1; m_first = 0; end
            else if (!ts && !tn && m_ack && ack_done) begin
                if (!m_first) m_first = 1;
                else begin m_ack = 0; m_first = 0; tk = 1; m_vec = ack_data; end
            end
            if (tn) begin m_req = 0; m_busy = 1; m_pend = ev; end
            else if (iret_s && m_busy) begin m_busy = 0; m_req = m_pend || ev; m_pend = 0; end
            else if (ev) begin if (m_busy) m_pend = 1; else m_req = 1; end
            m_take = tk;
            m_ms2 = m_ms1; m_ms1 = mask_in; m_s2 = m_s1; m_s1 = nmi_in;
        end
    end

    // per-cycle comparison away from the clock edge
    always begin
        bit e_hx;
        @(negedge clk); #2;
        e_hx = halted && (m_req || (m_ms2 && ie_f && !m_busy));
        n_chk++;
        if (take !== m_take || vec !== m_vec || ack_req !== m_ack || hexit !== e_hx) begin
            n_fail++;
            $display("FAIL %s cycle compare (actual/expected): take %b/%b vec %h/%h ack %b/%b hexit %b/%b",
                     cur_req, take, m_take, vec, m_vec, ack_req, m_ack, hexit, e_hx);
        end
        if (take === 1'b1) obs_q.push_back(vec);
        if (ack_req === 1'b1) ack_seen = 1;
    end

    task automatic step(int n = 1);
        repeat (n) begin @(negedge clk); #3; end
    endtask
    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask
    task automatic boundary();
        bnd = 1; step(); bnd = 0; step();
    endtask
    task automatic ret();
        iret_s = 1; step(); iret_s = 0; step();
    endtask
    task automatic ack(logic [7:0] d);
        ack_done = 1; ack_data = d; step(); ack_done = 0; step();
    endtask
    task automatic nmi_pulse(int hi, int lo);
        nmi_in = 1; step(hi); nmi_in = 0; step(lo);
    endtask

    initial begin
        int n0;
        step(3);
        chk(take === 0 && vec === 8'h00 && ack_req === 0 && hexit === 0, "R10 reset outputs", int'(vec), 0);
        rst_n = 1; step(8);

        cur_req = "R1"; ie_f = 1; mask_in = 1;
        boundary();
        chk(ack_req === 0, "R1 unsynchronised request serviced", int'(ack_req), 0);
        mask_in = 0; step(4);

        cur_req = "R4"; mask_in = 1; step(3); n0 = obs_q.size();
        boundary();
        chk(ack_req === 1, "R4 ack request raised", int'(ack_req), 1);
        ack(8'h11);
        chk(ack_req === 1 && obs_q.size() == n0, "R4 held after first ack", obs_q.size(), n0);
        ack(8'h45);
        chk(obs_q.size() == n0 + 1 && vec === 8'h45 && ack_req === 0, "R4 vector from second ack", int'(vec), 'h45);
        mask_in = 0; step(3);

        cur_req = "R5"; ie_f = 0; mask_in = 1; step(4); n0 = obs_q.size(); ack_seen = 0;
        boundary(); step(2);
        chk(!ack_seen && obs_q.size() == n0, "R5 masked request", obs_q.size(), n0);
        mask_in = 0; step(3);

        cur_req = "R3"; ack_seen = 0; n0 = obs_q.size();
        nmi_pulse(6, 8);
        boundary();
        chk(obs_q.size() == n0 + 1 && vec === 8'h02, "R3 nmi vector", int'(vec), 2);
        chk(!ack_seen, "R3 no acknowledge", int'(ack_seen), 0);
        ret();

        cur_req = "R2"; n0 = obs_q.size();
        nmi_pulse(3, 8);
        boundary();
        chk(obs_q.size() == n0, "R2 short high pulse", obs_q.size(), n0);
        nmi_pulse(6, 2);
        nmi_pulse(6, 8);
        boundary();
        chk(obs_q.size() == n0 + 1, "R2 first pulse only", obs_q.size(), n0 + 1);
        ret(); step(4);
        boundary();
        chk(obs_q.size() == n0 + 1, "R2 short low gap", obs_q.size(), n0 + 1);

        cur_req = "R7"; nmi_pulse(6, 8); boundary(); n0 = obs_q.size();
        ie_f = 1; mask_in = 1; step(4); ack_seen = 0;
        boundary();
        chk(!ack_seen, "R7 maskable blocked in window", int'(ack_seen), 0);
        mask_in = 0; step(3);
        nmi_pulse(6, 8);
        cur_req = "R8"; nmi_pulse(6, 8);
        boundary();
        chk(obs_q.size() == n0, "R7 nmi blocked in window", obs_q.size(), n0);
        ret(); boundary();
        chk(obs_q.size() == n0 + 1 && vec === 8'h02, "R8 pending released", obs_q.size(), n0 + 1);
        ret(); boundary();
        chk(obs_q.size() == n0 + 1, "R8 extra event dropped", obs_q.size(), n0 + 1);

        cur_req = "R6"; mask_in = 1; ie_f = 1; nmi_pulse(6, 8); n0 = obs_q.size();
        trap_f = 1; boundary(); trap_f = 0; boundary(); ret(); boundary();
        ack(8'h33); ack(8'h5A); mask_in = 0; step(3);
        chk(obs_q.size() == n0 + 3, "R6 take count", obs_q.size(), n0 + 3);
        if (obs_q.size() == n0 + 3) begin
            chk(obs_q[n0] == 8'h01, "R6 step first", int'(obs_q[n0]), 1);
            chk(obs_q[n0+1] == 8'h02, "R6 nmi second", int'(obs_q[n0+1]), 2);
            chk(obs_q[n0+2] == 8'h5A, "R6 maskable last", int'(obs_q[n0+2]), 'h5A);
        end

        cur_req = "R9"; halted = 1; ie_f = 0; mask_in = 1; step(4);
        chk(hexit === 0, "R9 disabled maskable", int'(hexit), 0);
        ie_f = 1; step();
        chk(hexit === 1, "R9 enabled maskable", int'(hexit), 1);
        ie_f = 0; mask_in = 0; step(3);
        chk(hexit === 0, "R9 idle", int'(hexit), 0);
        nmi_pulse(6, 4);
        chk(hexit === 1, "R9 nmi wakes", int'(hexit), 1);
        halted = 0; boundary(); ret();

        cur_req = "R11"; ie_f = 1; mask_in = 1; step(3); boundary(); n0 = obs_q.size();
        trap_f = 1; boundary(); trap_f = 0;
        chk(ack_req === 1 && obs_q.size() == n0, "R11 boundary ignored during ack", obs_q.size(), n0);
        ack(8'h00); ack(8'h77); mask_in = 0; step(3);
        chk(obs_q.size() == n0 + 1 && vec === 8'h77, "R11 ack completes", int'(vec), 'h77);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule